// File: doc/BRIEF.md
# Chunked Hamming Parity Generator for NAND Transfers

This block watches a byte stream on its way to or from a NAND device and builds a single-error-correcting Hamming code over each group of 256 consecutive accepted bytes. A byte counts when its valid strobe is high. As each byte arrives, six column-parity bits and sixteen line-parity bits are folded into running accumulators. The column bits are indexed by bit position inside the byte, and the line bits by the byte's position inside the chunk.

When the 256th byte of a chunk is accepted, the finished 22-bit parity word is latched into an output register and a one-cycle done pulse is raised. The accumulators then start the next chunk from zero. At the same moment the block starts to stream the three-byte spare-area form of that word, most significant byte first. A synchronous clear input drops any partly accumulated chunk, so a new transfer can start cleanly.

Each chunk is independent of the ones before it. Comparing a stored word with a recomputed one is left to the consumer: a single flipped data bit shows up as a difference in exactly one bit of every parity pair.

Top module: `hecc_chunk_gen`

## Requirements
- R1: After reset, par_word is 0, chunk_done is 0 and ecc_vld is 0.
- R2: par_word[5:0] holds column parity. For c in 0..2, bit 2c is the XOR of every data bit whose in-byte position has bit c clear, and bit 2c+1 is the XOR of every data bit whose position has bit c set.
- R3: par_word[21:6] holds line parity. For j in 0..7, bit 6+2j is the XOR of the byte parities of all bytes whose chunk index (0..255, in order of acceptance) has bit j clear. Bit 7+2j covers the bytes whose index has bit j set.
- R4: Each chunk's word depends only on that chunk's 256 bytes. Back-to-back chunks do not mix.
- R5: chunk_done is high for exactly one cycle: the cycle after the 256th byte is accepted. par_word changes to the new word in that same cycle and holds it until the next chunk completes. No pulse comes after 255 bytes.
- R6: A cycle with byte_vld low does not advance the count or change any parity, whatever byte_in carries.
- R7: The stored form is S = ~(par_word << 2) taken to 24 bits. ecc_vld is high for three cycles, starting in the chunk_done cycle. ecc_byte carries S[23:16], then S[15:8], then S[7:0].
- R8: clr high for a cycle discards the partial chunk's count and parity and cancels any byte stream in progress. The next byte becomes index 0 of a fresh chunk. par_word keeps its last value.
- R9: If two chunks differ in exactly one data bit, their words differ in exactly one bit of each of the 11 parity pairs, which is 11 bits in all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of accumulation |
| byte_vld | input | 1 | byte_in is accepted this cycle |
| byte_in | input | 8 | Data byte |
| par_word | output | 22 | Last completed parity word |
| chunk_done | output | 1 | One-cycle pulse when par_word updates |
| ecc_vld | output | 1 | ecc_byte carries a stored-form byte |
| ecc_byte | output | 8 | Stored-form byte, most significant first |

## Verification
The bench goes after the chunk boundary. A design that is off by one would pulse after 255 bytes, or would carry the first byte of the next chunk into the previous word. Idle cycles with junk on the data input are mixed into the stream: a design that samples without the strobe ends up with a wrong word and a shifted boundary. A clear in the middle of a chunk followed by a full chunk exposes a design that keeps stale parity or a stale count. A single-bit flip between two otherwise equal chunks exposes swapped even and odd halves, a wrong address bit, or the wrong byte order in the stored-form stream.

// File: rtl/hecc_chunk_gen.sv
module hecc_chunk_gen #(
  parameter int CHUNK = 256
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            byte_vld,
  input  logic [7:0]                      byte_in,
  output logic [6+2*$clog2(CHUNK)-1:0]    par_word,
  output logic                            chunk_done,
  output logic                            ecc_vld,
  output logic [7:0]                      ecc_byte
);
  localparam int AW = $clog2(CHUNK);
  localparam int PW = 6 + 2*AW;
  localparam int SB = (PW + 2 + 7) / 8;
  localparam int SW = 8*SB;
  localparam int EW = $clog2(SB + 1);

  logic [AW-1:0]   idx;
  logic [5:0]      col_acc, col_in;
  logic [2*AW-1:0] lin_acc, lin_in;
  logic [EW-1:0]   ems;
  logic [SW-1:0]   stored;
  logic            bp;

  assign bp = ^byte_in;

  always_comb begin
    col_in = '0;
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 8; k++)
        if (byte_in[k]) col_in[2*c + ((k >> c) & 1)] ^= 1'b1;
  end

  always_comb begin
    lin_in = '0;
    for (int j = 0; j < AW; j++)
      lin_in[2*j + int'(idx[j])] = bp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      col_acc    <= '0;
      lin_acc    <= '0;
      par_word   <= '0;
      chunk_done <= 1'b0;
      ems        <= '0;
    end else if (clr) begin
      idx        <= '0;
      col_acc    <= '0;
      lin_acc    <= '0;
      chunk_done <= 1'b0;
      ems        <= '0;
    end else begin
      chunk_done <= 1'b0;
      if (ems != '0) ems <= ems - EW'(1);
      if (byte_vld) begin
        if (idx == AW'(CHUNK-1)) begin
          par_word   <= {lin_acc ^ lin_in, col_acc ^ col_in};
          col_acc    <= '0;
          lin_acc    <= '0;
          idx        <= '0;
          chunk_done <= 1'b1;
          ems        <= EW'(SB);
        end else begin
          col_acc <= col_acc ^ col_in;
          lin_acc <= lin_acc ^ lin_in;
          idx     <= idx + AW'(1);
        end
      end
    end
  end

  assign stored  = ~(SW'({par_word, 2'b00}));
  assign ecc_vld = (ems != '0);

  always_comb begin
    ecc_byte = 8'h00;
    if (ems != '0) ecc_byte = 8'(stored >> (8*(int'(ems) - 1)));
  end

  function automatic logic pairs_agree(input logic [PW-1:0] w);
    logic ref_bit;
    ref_bit = w[0] ^ w[1];
    pairs_agree = 1'b1;
    for (int p = 1; p < PW/2; p++)
      if ((w[2*p] ^ w[2*p+1]) != ref_bit) pairs_agree = 1'b0;
  endfunction

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> !chunk_done);
  // R7
  emit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> ecc_vld);
  // R8
  clr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!chunk_done && !ecc_vld));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !clr) |=> $stable(par_word));
  // R9
  pair_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> pairs_agree(par_word));
endmodule

// File: tb/sim_hecc_chunk_gen.sv
module sim_hecc_chunk_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [21:0] par_word;
  logic        chunk_done, ecc_vld;
  logic [7:0]  ecc_byte;

  hecc_chunk_gen u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(byte_vld),
    .byte_in(byte_in), .par_word(par_word), .chunk_done(chunk_done),
    .ecc_vld(ecc_vld), .ecc_byte(ecc_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, dones = 0;
  bit finished = 0;
  logic [21:0] expq[$];
  logic [21:0] seen[$];
  logic [7:0]  bufA [256];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] ref_par(input logic [7:0] b [256]);
    logic [5:0]  col = '0;
    logic [15:0] lin = '0;
    for (int i = 0; i < 256; i++)
      for (int k = 0; k < 8; k++)
        if (b[i][k]) begin
          for (int c = 0; c < 3; c++) col[2*c + ((k >> c) & 1)] ^= 1'b1;
          for (int j = 0; j < 8; j++) lin[2*j + ((i >> j) & 1)] ^= 1'b1;
        end
    return {lin, col};
  endfunction

  task automatic send_chunk(input bit gaps);
    expq.push_back(ref_par(bufA));
    for (int i = 0; i < 256; i++) begin
      if (gaps) repeat ($urandom % 3) begin
        @(negedge clk); byte_vld = 1'b0; byte_in = 8'($urandom);
      end
      @(negedge clk); byte_vld = 1'b1; byte_in = bufA[i];
    end
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 256; i++) bufA[i] = 8'($urandom);
  endtask

  // monitor: pops expected words, checks word and stored-byte stream
  initial begin
    logic [21:0] e;
    logic [23:0] s;
    forever begin
      @(negedge clk);
      if (rst_n && chunk_done) begin
        dones++;
        seen.push_back(par_word);
        if (expq.size() == 0) chk(1'b0, "R5 unexpected done", 32'(par_word), 32'h0);
        else begin
          e = expq.pop_front();
          s = ~{e, 2'b00};
          chk(par_word == e, "R2 R3 R4 parity word", 32'(par_word), 32'(e));
          chk(ecc_vld && ecc_byte == s[23:16], "R7 stored byte 0", 32'(ecc_byte), 32'(s[23:16]));
          @(negedge clk);
          chk(ecc_vld && ecc_byte == s[15:8], "R7 stored byte 1", 32'(ecc_byte), 32'(s[15:8]));
          @(negedge clk);
          chk(ecc_vld && ecc_byte == s[7:0], "R7 stored byte 2", 32'(ecc_byte), 32'(s[7:0]));
          @(negedge clk);
          chk(!ecc_vld, "R7 stream length", 32'(ecc_vld), 32'h0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [21:0] held, d;
    int n0, bitpos;
    bit pairs_ok;
    repeat (3) @(negedge clk);
    chk(par_word == '0 && !chunk_done && !ecc_vld, "R1 reset state",
        {8'(chunk_done), 2'(ecc_vld), par_word}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: random, continuous
    fill_rand(); send_chunk(1'b0);
    // R6: gaps with junk data
    fill_rand(); send_chunk(1'b1);
    // all zeros: word 0, stored FF FF FF
    for (int i = 0; i < 256; i++) bufA[i] = 8'h00;
    send_chunk(1'b0);
    repeat (6) @(negedge clk);
    chk(par_word == 22'h0, "R2 R3 zero chunk", 32'(par_word), 32'h0);

    // R6: idle with junk
    held = par_word; n0 = dones;
    repeat (20) begin @(negedge clk); byte_vld = 1'b0; byte_in = 8'($urandom); end
    chk(par_word == held && dones == n0, "R6 idle ignored", 32'(par_word), 32'(held));

    // R9: single bit flip
    fill_rand(); send_chunk(1'b0);
    bitpos = $urandom % 2048;
    bufA[bitpos/8][bitpos%8] = ~bufA[bitpos/8][bitpos%8];
    send_chunk(1'b0);
    repeat (6) @(negedge clk);
    d = seen[seen.size()-1] ^ seen[seen.size()-2];
    pairs_ok = 1'b1;
    for (int p = 0; p < 11; p++) if ((d[2*p] ^ d[2*p+1]) != 1'b1) pairs_ok = 1'b0;
    chk($countones(d) == 11 && pairs_ok, "R9 single flip signature", 32'(d), 32'h0);

    // R8: clear mid-chunk
    held = par_word; n0 = dones;
    for (int i = 0; i < 100; i++) begin @(negedge clk); byte_vld = 1'b1; byte_in = 8'($urandom); end
    @(negedge clk); byte_vld = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(par_word == held && dones == n0, "R8 word kept after clear", 32'(par_word), 32'(held));
    fill_rand(); send_chunk(1'b1);

    // R5: boundary timing
    repeat (6) @(negedge clk);
    fill_rand();
    expq.push_back(ref_par(bufA));
    n0 = dones;
    for (int i = 0; i < 255; i++) begin @(negedge clk); byte_vld = 1'b1; byte_in = bufA[i]; end
    @(negedge clk); byte_vld = 1'b0;
    @(negedge clk);
    chk(!chunk_done && dones == n0, "R5 no done after 255", 32'(dones), 32'(n0));
    byte_vld = 1'b1; byte_in = bufA[255];
    @(negedge clk); byte_vld = 1'b0;
    chk(chunk_done == 1'b1, "R5 done after 256th", 32'(chunk_done), 32'h1);
    @(negedge clk);
    chk(chunk_done == 1'b0, "R5 single cycle pulse", 32'(chunk_done), 32'h0);

    // R4: back-to-back chunks
    repeat (4) @(negedge clk);
    fill_rand(); send_chunk(1'b0);
    fill_rand(); send_chunk(1'b0);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R5 missing done", 32'(expq.size()), 32'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule